// File: doc/BRIEF.md
# Camera Frame Sync and Interrupt Unit

This unit paces an external image sensor by generating the sensor's vertical sync itself. The sensor drives only the horizontal reference; the unit counts that signal's falling edges to decide when the active part of a frame is over. It then either asserts vertical sync at once, or waits for a line-match strobe from the display timing so that each camera frame starts in step with the display. Vertical sync stays high for a programmed number of line periods, each a programmed number of clock cycles. The default frame is 480 lines, which suits a 640x480 sensor at 30 frames per second.

Four events are recorded in a status word: frame start (bit 0), active lines complete (bit 1), vertical sync start (bit 2) and a stray line seen while no frame was active (bit 5). Software clears them by writing ones to the same status word. The status bits that are also set in an enable mask are ORed onto one level interrupt.

The sequencer has four states. IDLE: stopped, sync low. VSYNC: sync high, line periods counted. ACTIVE: sync low, sensor lines counted. WAIT_DISP: active lines are done and the unit is held until the display strobe arrives. Transitions: IDLE to VSYNC, or to WAIT_DISP when display sync is on, once run is set; VSYNC to ACTIVE when the sync length is reached; ACTIVE to VSYNC, or to WAIT_DISP when display sync is on, on the last counted line; WAIT_DISP to VSYNC on the display strobe; any state to IDLE when run is cleared.

Top module: `cam_fsync_top`

## Requirements
- R1: After reset, vsync_o and irq_o are low. Reads return: address 0 (control; bit 0 run, bit 1 display sync) = 0, address 1 (enable mask) = 0, address 2 (status) = 0, address 3 (lines per frame) = 480, address 4 (sync lines) = 3, address 5 (clocks per line period) = 800.
- R2: While running, each vsync_o pulse lasts exactly (sync lines) x (clocks per line period) clock cycles.
- R3: In ACTIVE, the frame ends on the Nth falling edge of href_i, N being the lines-per-frame value. With display sync off, vsync_o is high in the cycle after the clock edge that samples that falling edge, and stays low before it.
- R4: With display sync on, vsync_o stays low after the last line until line_match_i is sampled high; vsync_o is high in the cycle after that edge. Status bit 1 is set while waiting.
- R5: Status bit 0 is set when vsync_o ends while running, marking the start of a new frame.
- R6: Status bit 2 is set whenever vsync_o starts; status bit 1 when the active lines are complete; status bit 5 when an href_i falling edge arrives in VSYNC or WAIT_DISP.
- R7: Writing the status address clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R9: irq_o is high exactly when some status bit is set whose enable mask bit is set.
- R10: Clearing run drives vsync_o low within two cycles of the write and holds it low; setting run again starts with a full vsync_o pulse.
- R11: A value of 0 in lines per frame, sync lines or clocks per line period acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| href_i | input | 1 | Sensor horizontal reference, synchronous to clk |
| line_match_i | input | 1 | Display line-match strobe |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| vsync_o | output | 1 | Vertical sync to the sensor |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions watch every cycle for rules that stay local in time. An enabled event must raise the interrupt on the next cycle. A cleared run bit must drop sync. Sync may not rise while the unit waits for the display strobe. The end of sync must leave the frame-start flag set. A clear must take effect unless an event of the same bit arrives with it. Exact sync pulse lengths, the line on which a frame ends, the field and address layout and the zero-as-one rule depend on whole frames and programmed values. Only the bench's directed and random frame scenarios can show those.

// File: rtl/cam_fsync_pkg.sv
package cam_fsync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_VSYNC     = 2'd1,
        ST_ACTIVE    = 2'd2,
        ST_WAIT_DISP = 2'd3
    } fs_state_e;

    localparam int EV_W           = 8;
    localparam int EV_FRAME_START = 0;
    localparam int EV_LINES_DONE  = 1;
    localparam int EV_VSYNC_START = 2;
    localparam int EV_STRAY_LINE  = 5;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL        = 3'd0;
    localparam logic [ADDR_W-1:0] A_IRQ_EN      = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS      = 3'd2;
    localparam logic [ADDR_W-1:0] A_FRAME_LINES = 3'd3;
    localparam logic [ADDR_W-1:0] A_SYNC_LINES  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LINE_CLKS   = 3'd5;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_DISP = 1;

endpackage

// File: rtl/cam_fsync_edge.sv
module cam_fsync_edge #(
    parameter int IN_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic href_i,
    output logic fall_o
);

    logic [IN_STAGES:0] pipe;
    logic               href_q;

    assign pipe[0] = href_i;

    for (genvar g = 0; g < IN_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[g+1] <= 1'b0;
            end else begin
                pipe[g+1] <= pipe[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            href_q <= 1'b0;
        end else begin
            href_q <= pipe[IN_STAGES];
        end
    end

    assign fall_o = href_q & ~pipe[IN_STAGES];

endmodule

// File: rtl/cam_fsync_seq.sv
module cam_fsync_seq
    import cam_fsync_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int VS_W   = 8,
    parameter int CLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              disp_sync_i,
    input  logic [LINE_W-1:0] frame_lines_i,
    input  logic [VS_W-1:0]   sync_lines_i,
    input  logic [CLK_W-1:0]  line_clks_i,
    input  logic              href_fall_i,
    input  logic              line_match_i,
    output logic              vsync_o,
    output logic              wait_o,
    output logic [EV_W-1:0]   ev_o
);

    fs_state_e state_q, state_d;

    logic [LINE_W-1:0] line_cnt_q;
    logic [VS_W-1:0]   vs_cnt_q;
    logic [CLK_W-1:0]  clk_cnt_q;

    logic [LINE_W-1:0] fl_eff;
    logic [VS_W-1:0]   vs_eff;
    logic [CLK_W-1:0]  lc_eff;
    logic [LINE_W:0]   line_next;
    logic [VS_W:0]     vs_next;
    logic [CLK_W:0]    clk_next;
    logic              period_tick;
    logic              sync_done;
    logic              lines_done;

    // zero-valued limits behave as one (R11)
    assign fl_eff = (frame_lines_i == '0) ? LINE_W'(1) : frame_lines_i;
    assign vs_eff = (sync_lines_i  == '0) ? VS_W'(1)   : sync_lines_i;
    assign lc_eff = (line_clks_i   == '0) ? CLK_W'(1)  : line_clks_i;

    assign line_next = {1'b0, line_cnt_q} + (LINE_W+1)'(1);
    assign vs_next   = {1'b0, vs_cnt_q}   + (VS_W+1)'(1);
    assign clk_next  = {1'b0, clk_cnt_q}  + (CLK_W+1)'(1);

    assign period_tick = (clk_next >= {1'b0, lc_eff});
    assign sync_done   = period_tick && (vs_next >= {1'b0, vs_eff});
    assign lines_done  = href_fall_i && (line_next >= {1'b0, fl_eff});

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) begin
                    state_d = disp_sync_i ? ST_WAIT_DISP : ST_VSYNC;
                end
            end
            ST_VSYNC: begin
                if (sync_done) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (lines_done) begin
                    state_d = disp_sync_i ? ST_WAIT_DISP : ST_VSYNC;
                end
            end
            ST_WAIT_DISP: begin
                if (line_match_i) begin
                    state_d = ST_VSYNC;
                end
            end
        endcase
        if (!run_i) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt_q <= '0;
            vs_cnt_q   <= '0;
            clk_cnt_q  <= '0;
        end else if (state_q != state_d) begin
            line_cnt_q <= '0;
            vs_cnt_q   <= '0;
            clk_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_VSYNC: begin
                    if (period_tick) begin
                        clk_cnt_q <= '0;
                        vs_cnt_q  <= vs_next[VS_W-1:0];
                    end else begin
                        clk_cnt_q <= clk_next[CLK_W-1:0];
                    end
                end
                ST_ACTIVE: begin
                    if (href_fall_i) begin
                        line_cnt_q <= line_next[LINE_W-1:0];
                    end
                end
                ST_IDLE, ST_WAIT_DISP: begin
                    line_cnt_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        vsync_o = (state_q == ST_VSYNC);
        wait_o  = (state_q == ST_WAIT_DISP);
        ev_o    = '0;
        ev_o[EV_FRAME_START] = run_i && (state_q == ST_VSYNC) && sync_done;
        ev_o[EV_LINES_DONE]  = run_i && (state_q == ST_ACTIVE) && lines_done;
        ev_o[EV_VSYNC_START] = run_i && (state_q != ST_VSYNC) && (state_d == ST_VSYNC);
        ev_o[EV_STRAY_LINE]  = run_i && href_fall_i &&
                               ((state_q == ST_VSYNC) || (state_q == ST_WAIT_DISP));
    end

endmodule

// File: rtl/cam_fsync_regs.sv
module cam_fsync_regs
    import cam_fsync_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter int LINE_W          = 12,
    parameter int VS_W            = 8,
    parameter int CLK_W           = 16,
    parameter int DEF_FRAME_LINES = 480,
    parameter int DEF_SYNC_LINES  = 3,
    parameter int DEF_LINE_CLKS   = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [EV_W-1:0]   ev_i,
    output logic              run_o,
    output logic              disp_sync_o,
    output logic [LINE_W-1:0] frame_lines_o,
    output logic [VS_W-1:0]   sync_lines_o,
    output logic [CLK_W-1:0]  line_clks_o,
    output logic [EV_W-1:0]   en_mask_o,
    output logic [EV_W-1:0]   status_o,
    output logic              irq_o
);

    logic [EV_W-1:0] status_q;
    logic [EV_W-1:0] en_q;
    logic [EV_W-1:0] clr_mask;
    logic            wr_ctrl, wr_en, wr_stat, wr_fl, wr_vs, wr_lc;
    wire             unused_wdata = ^cfg_wdata;

    assign wr_ctrl = cfg_we && (cfg_addr == A_CTRL);
    assign wr_en   = cfg_we && (cfg_addr == A_IRQ_EN);
    assign wr_stat = cfg_we && (cfg_addr == A_STATUS);
    assign wr_fl   = cfg_we && (cfg_addr == A_FRAME_LINES);
    assign wr_vs   = cfg_we && (cfg_addr == A_SYNC_LINES);
    assign wr_lc   = cfg_we && (cfg_addr == A_LINE_CLKS);

    assign clr_mask = wr_stat ? cfg_wdata[EV_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o         <= 1'b0;
            disp_sync_o   <= 1'b0;
            en_q          <= '0;
            frame_lines_o <= LINE_W'(DEF_FRAME_LINES);
            sync_lines_o  <= VS_W'(DEF_SYNC_LINES);
            line_clks_o   <= CLK_W'(DEF_LINE_CLKS);
        end else begin
            if (wr_ctrl) begin
                run_o       <= cfg_wdata[CTRL_RUN];
                disp_sync_o <= cfg_wdata[CTRL_DISP];
            end
            if (wr_en) en_q          <= cfg_wdata[EV_W-1:0];
            if (wr_fl) frame_lines_o <= cfg_wdata[LINE_W-1:0];
            if (wr_vs) sync_lines_o  <= cfg_wdata[VS_W-1:0];
            if (wr_lc) line_clks_o   <= cfg_wdata[CLK_W-1:0];
        end
    end

    // write-one-to-clear; a simultaneous event keeps its bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | ev_i;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            A_CTRL:        cfg_rdata = DATA_W'({disp_sync_o, run_o});
            A_IRQ_EN:      cfg_rdata = DATA_W'(en_q);
            A_STATUS:      cfg_rdata = DATA_W'(status_q);
            A_FRAME_LINES: cfg_rdata = DATA_W'(frame_lines_o);
            A_SYNC_LINES:  cfg_rdata = DATA_W'(sync_lines_o);
            A_LINE_CLKS:   cfg_rdata = DATA_W'(line_clks_o);
            default:       cfg_rdata = '0;
        endcase
    end

    assign en_mask_o = en_q;
    assign status_o  = status_q;
    assign irq_o     = |(status_q & en_q);

endmodule

// File: rtl/cam_fsync_top.sv
module cam_fsync_top
    import cam_fsync_pkg::*;
#(
    parameter int DATA_W          = 32,
    parameter int LINE_W          = 12,
    parameter int VS_W            = 8,
    parameter int CLK_W           = 16,
    parameter int IN_STAGES       = 0,
    parameter int DEF_FRAME_LINES = 480,
    parameter int DEF_SYNC_LINES  = 3,
    parameter int DEF_LINE_CLKS   = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              href_i,
    input  logic              line_match_i,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              vsync_o,
    output logic              irq_o
);

    logic              href_fall;
    logic              run_en;
    logic              disp_en;
    logic [LINE_W-1:0] frame_lines;
    logic [VS_W-1:0]   sync_lines;
    logic [CLK_W-1:0]  line_clks;
    logic [EV_W-1:0]   ev_pulse;
    logic [EV_W-1:0]   en_mask;
    logic [EV_W-1:0]   status_q;
    logic              in_wait;

    cam_fsync_edge #(
        .IN_STAGES (IN_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .href_i (href_i),
        .fall_o (href_fall)
    );

    cam_fsync_seq #(
        .LINE_W (LINE_W),
        .VS_W   (VS_W),
        .CLK_W  (CLK_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run_en),
        .disp_sync_i   (disp_en),
        .frame_lines_i (frame_lines),
        .sync_lines_i  (sync_lines),
        .line_clks_i   (line_clks),
        .href_fall_i   (href_fall),
        .line_match_i  (line_match_i),
        .vsync_o       (vsync_o),
        .wait_o        (in_wait),
        .ev_o          (ev_pulse)
    );

    cam_fsync_regs #(
        .DATA_W          (DATA_W),
        .LINE_W          (LINE_W),
        .VS_W            (VS_W),
        .CLK_W           (CLK_W),
        .DEF_FRAME_LINES (DEF_FRAME_LINES),
        .DEF_SYNC_LINES  (DEF_SYNC_LINES),
        .DEF_LINE_CLKS   (DEF_LINE_CLKS)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .ev_i          (ev_pulse),
        .run_o         (run_en),
        .disp_sync_o   (disp_en),
        .frame_lines_o (frame_lines),
        .sync_lines_o  (sync_lines),
        .line_clks_o   (line_clks),
        .en_mask_o     (en_mask),
        .status_o      (status_q),
        .irq_o         (irq_o)
    );

endmodule

// File: rtl/cam_fsync_chk.sv
module cam_fsync_chk
    import cam_fsync_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            vsync_o,
    input logic            irq_o,
    input logic            line_match_i,
    input logic            in_wait,
    input logic            run_en,
    input logic            stat_wr,
    input logic            en_wr,
    input logic            ack1,
    input logic [EV_W-1:0] ev_pulse,
    input logic [EV_W-1:0] en_mask,
    input logic            st0,
    input logic            st1
);

    assert_enabled_event_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ev_pulse & en_mask)) && !en_wr) |=> irq_o);

    assert_stop_drops_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !vsync_o);

    assert_frame_start_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_o) && $past(run_en) && run_en) |-> st0);

    assert_hold_until_display_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !line_match_i) |=> !vsync_o);

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[EV_FRAME_START] |=> st0);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && ack1 && !ev_pulse[EV_LINES_DONE]) |=> !st1);

endmodule

bind cam_fsync_top cam_fsync_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync_o      (vsync_o),
    .irq_o        (irq_o),
    .line_match_i (line_match_i),
    .in_wait      (in_wait),
    .run_en       (run_en),
    .stat_wr      (cfg_we && (cfg_addr == cam_fsync_pkg::A_STATUS)),
    .en_wr        (cfg_we && (cfg_addr == cam_fsync_pkg::A_IRQ_EN)),
    .ack1         (cfg_wdata[1]),
    .ev_pulse     (ev_pulse),
    .en_mask      (en_mask),
    .st0          (status_q[0]),
    .st1          (status_q[1])
);

// File: tb/cam_fsync_top_test.sv
module cam_fsync_top_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] R_CTRL = 3'd0, R_EN = 3'd1, R_STAT = 3'd2,
                           R_FL = 3'd3, R_VS = 3'd4, R_LC = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        href = 1'b0;
    logic        lm = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    wire  [31:0] rdata;
    wire         vsync;
    wire         irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_fsync_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .href_i       (href),
        .line_match_i (lm),
        .cfg_we       (we),
        .cfg_addr     (addr),
        .cfg_wdata    (wdata),
        .cfg_rdata    (rdata),
        .vsync_o      (vsync),
        .irq_o        (irq)
    );

    function automatic int exp_sync_len(int vs, int lc);
        return ((vs == 0) ? 1 : vs) * ((lc == 0) ? 1 : lc);
    endfunction

    function automatic bit exp_irq(logic [31:0] st, logic [31:0] m);
        return |(st[7:0] & m[7:0]);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic measure_sync(output int len);
        int t = 0;
        while (!vsync && t < 2000) begin
            @(negedge clk);
            t++;
        end
        len = 0;
        while (vsync && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    // one sensor line; vs_after is vsync one cycle after the falling edge is sampled
    task automatic send_line(int hi, int lo, output bit vs_after);
        href = 1'b1;
        repeat (hi) @(negedge clk);
        href = 1'b0;
        @(negedge clk);
        vs_after = vsync;
        repeat (lo - 1) @(negedge clk);
    endtask

    task automatic send_frame(int n, int hi, int lo, bit sync_expected, string req);
        bit v;
        for (int i = 1; i <= n; i++) begin
            send_line(hi, (i == n) ? 1 : lo, v);
            if (i < n) check(v == 1'b0, req, "vsync before last line", v, 0);
            else       check(v == sync_expected, req, "vsync after last line", v, sync_expected);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int len;
        void'($urandom(32'h5eed_c0de));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check(vsync == 1'b0, "R1", "vsync", vsync, 0);
        check(irq == 1'b0, "R1", "irq", irq, 0);
        rd(R_CTRL, r); check(r == 0, "R1", "ctrl", r, 0);
        rd(R_EN, r);   check(r == 0, "R1", "enable", r, 0);
        rd(R_STAT, r); check(r == 0, "R1", "status", r, 0);
        rd(R_FL, r);   check(r == 480, "R1", "frame lines", r, 480);
        rd(R_VS, r);   check(r == 3, "R1", "sync lines", r, 3);
        rd(R_LC, r);   check(r == 800, "R1", "line clocks", r, 800);

        // R2 first pulse after start, R5/R6 flags
        wr(R_FL, 4); wr(R_VS, 2); wr(R_LC, 3);
        wr(R_CTRL, 1);
        measure_sync(len);
        check(len == exp_sync_len(2, 3), "R2", "first sync length", len, exp_sync_len(2, 3));
        rd(R_STAT, r); check(r == 32'h05, "R5", "status after first sync", r, 5);

        // R3 line counting, R6 lines-done flag
        send_frame(4, 2, 3, 1'b1, "R3");
        measure_sync(len);
        check(len == 6, "R2", "frame sync length", len, 6);
        rd(R_STAT, r); check(r == 32'h07, "R6", "status after frame", r, 7);

        // R7 write-one-to-clear
        wr(R_STAT, 32'h2); rd(R_STAT, r); check(r == 32'h05, "R7", "clear bit1", r, 5);
        wr(R_STAT, 32'h0); rd(R_STAT, r); check(r == 32'h05, "R7", "zero write", r, 5);
        wr(R_STAT, 32'hFF); rd(R_STAT, r); check(r == 32'h0, "R7", "clear all", r, 0);

        // R8 clear coinciding with frame-start event
        send_frame(4, 1, 2, 1'b1, "R3");
        repeat (5) @(negedge clk);
        check(vsync == 1'b1, "R8", "last sync cycle", vsync, 1);
        we = 1'b1; addr = R_STAT; wdata = 32'h3;
        @(negedge clk);
        we = 1'b0;
        check(vsync == 1'b0, "R8", "sync ended", vsync, 0);
        rd(R_STAT, r); check(r == 32'h05, "R8", "event wins over clear", r, 5);

        // R9 interrupt against random masks
        for (int k = 0; k < 8; k++) begin
            logic [31:0] m;
            m = $urandom & 32'hFF;
            if (k == 0) m = 32'h0;
            if (k == 1) m = 32'h02;
            if (k == 2) m = 32'h04;
            wr(R_EN, m);
            rd(R_STAT, r);
            check(irq == exp_irq(r, m), "R9", "irq level", irq, exp_irq(r, m));
        end
        wr(R_EN, 0);

        // R6 stray line during sync
        wr(R_STAT, 32'hFF);
        send_frame(4, 2, 2, 1'b1, "R3");
        href = 1'b1;
        @(negedge clk);
        href = 1'b0;
        measure_sync(len);
        rd(R_STAT, r); check(r == 32'h27, "R6", "stray line flag", r, 32'h27);

        // R4 display sync hold-off
        wr(R_STAT, 32'hFF);
        wr(R_CTRL, 3);
        send_frame(4, 2, 2, 1'b0, "R4");
        repeat (10) @(negedge clk);
        check(vsync == 1'b0, "R4", "held while waiting", vsync, 0);
        rd(R_STAT, r); check(r == 32'h02, "R4", "status while waiting", r, 2);
        lm = 1'b1;
        @(negedge clk);
        lm = 1'b0;
        check(vsync == 1'b1, "R4", "sync after strobe", vsync, 1);
        measure_sync(len);
        check(len == 6, "R4", "sync length after strobe", len, 6);

        // R10 stop during sync, then restart
        wr(R_CTRL, 1);
        send_frame(4, 2, 2, 1'b1, "R3");
        we = 1'b1; addr = R_CTRL; wdata = 32'h0;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        check(vsync == 1'b0, "R10", "sync dropped on stop", vsync, 0);
        repeat (20) @(negedge clk);
        check(vsync == 1'b0, "R10", "sync stays low", vsync, 0);
        wr(R_CTRL, 1);
        measure_sync(len);
        check(len == 6, "R10", "restart sync length", len, 6);

        // R11 zero limits act as one
        wr(R_CTRL, 0); wr(R_FL, 0); wr(R_VS, 0); wr(R_LC, 0);
        wr(R_CTRL, 1);
        measure_sync(len);
        check(len == 1, "R11", "zero sync length", len, 1);
        send_frame(1, 2, 2, 1'b1, "R11");
        measure_sync(len);
        check(len == 1, "R11", "zero sync after one line", len, 1);

        // random frames: R2 and R3 against the model
        for (int it = 0; it < 20; it++) begin
            int fl, vs, lc, hi, lo;
            fl = 1 + ($urandom % 6);
            vs = $urandom % 4;
            lc = $urandom % 5;
            hi = 1 + ($urandom % 3);
            lo = 1 + ($urandom % 3);
            wr(R_CTRL, 0);
            wr(R_FL, fl); wr(R_VS, vs); wr(R_LC, lc);
            wr(R_CTRL, 1);
            measure_sync(len);
            check(len == exp_sync_len(vs, lc), "R2", "random start sync", len, exp_sync_len(vs, lc));
            send_frame(fl, hi, lo, 1'b1, "R3");
            measure_sync(len);
            check(len == exp_sync_len(vs, lc), "R2", "random frame sync", len, exp_sync_len(vs, lc));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule